// File: doc/BRIEF.md
# Serial Scan Signature Compactor

This block folds the serial response bits returning from a local scan chain into a 16-bit signature. A test can then compare one short word against a precomputed value instead of the whole response vector, so many chains can run at once and each is checked only through its own signature. The signature register advances one step per captured bit, and only while the compactor is enabled and the scan path is in its data-shift phase. In every other cycle it holds its value.

Readout uses a separate shadow register. A load pulse copies the signature into the shadow, and while the read path is selected the shadow shifts toward the serial output. Reading therefore never disturbs the compaction register, and while the read path is selected the compaction register is frozen.

Top module: `sig_compactor`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it rises, `sig_out` is 0x0000 and `read_tdo` is 0.
- R2: On an advancing edge, the new signature is computed as follows. Let s be the current signature and d the serial bit. Form f = s[15] XOR d. The new value is (s shifted left by one, with bit 0 cleared), XORed with 0x100B if f is 1. 0x100B sets bits 12, 3, 1 and 0.
- R3: The signature advances only on a rising `clk` edge where `compact_en`=1, `scan_shift`=1 and `read_sel`=0. On any other edge it keeps its value.
- R4: When the signature starts at 0x0000, an all-zero input stream leaves it at 0x0000.
- R5: A rising edge with `read_load`=1 copies `sig_out` into the shadow register. After that edge, `read_tdo` shows bit 0 of the copied value.
- R6: A rising edge with `read_sel`=1, `scan_shift`=1 and `read_load`=0 shifts the shadow right by one and fills its top bit with 0. After sixteen such shifts from a load, the signature has appeared on `read_tdo` LSB first.
- R7: When `read_load`=1 and a shift condition hold on the same edge, the load wins.
- R8: While `read_sel`=1, `sig_out` is unchanged even if `compact_en`, `scan_shift` and `scan_bit` all toggle.
- R9: After a reset, the same input stream always produces the same signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| compact_en | input | 1 | Enables compaction of incoming bits |
| scan_shift | input | 1 | High while the scan path is in its data-shift phase |
| scan_bit | input | 1 | Serial bit returning from the local scan chain |
| read_sel | input | 1 | Selects the readout path; freezes compaction |
| read_load | input | 1 | Copies the signature into the readout shadow |
| sig_out | output | 16 | Current signature |
| read_tdo | output | 1 | Serial readout bit, LSB first |

## Verification
The assertions assume that `rst_n` is applied for at least one edge before any check, and that all inputs are driven to known levels from time zero. They also assume that `scan_bit` is known whenever the signature advances. The bench meets these assumptions by driving every input at the falling edge from a defined idle value and holding reset for several cycles. It never leaves an input unassigned. It raises `read_load` and `read_sel` only around readout, except in the directed test that overlaps them on purpose to exercise the load priority.

// File: rtl/sigc_pkg.sv
package sigc_pkg;
   localparam int           SIGC_W    = 16;
   localparam logic [15:0]  SIGC_POLY = 16'h100B;

   typedef enum logic [1:0] {
      RD_HOLD  = 2'd0,
      RD_LOAD  = 2'd1,
      RD_SHIFT = 2'd2
   } rd_op_e;
endpackage

// File: rtl/sigc_core.sv
module sigc_core #(
   parameter int               WIDTH = sigc_pkg::SIGC_W,
   parameter logic [WIDTH-1:0] POLY  = WIDTH'(sigc_pkg::SIGC_POLY)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   input  logic             din,
   output logic [WIDTH-1:0] st_q
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("sigc_core: WIDTH must be at least 2");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("sigc_core: polynomial constant term must be set");
   end

   logic             fb;
   logic [WIDTH-1:0] nxt;

   assign fb = st_q[MSB] ^ din;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i == 0) begin : g_lsb
         assign nxt[i] = POLY[i] & fb;
      end else begin : g_mid
         assign nxt[i] = st_q[i-1] ^ (POLY[i] & fb);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        st_q <= '0;
      else if (step_en)  st_q <= nxt;
   end

   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(st_q));

   // R4
   zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !din && st_q == '0) |=> (st_q == '0));
endmodule

// File: rtl/sigc_readout.sv
module sigc_readout #(
   parameter int WIDTH     = sigc_pkg::SIGC_W,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  sigc_pkg::rd_op_e      op,
   input  logic [WIDTH-1:0]      par_in,
   output logic                  ser_out
);
   import sigc_pkg::*;

   logic [WIDTH-1:0] sh_q;
   logic [WIDTH-1:0] sh_next;

   if (LSB_FIRST) begin : g_lsb_first
      assign sh_next = {1'b0, sh_q[WIDTH-1:1]};
      assign ser_out = sh_q[0];
   end else begin : g_msb_first
      assign sh_next = {sh_q[WIDTH-2:0], 1'b0};
      assign ser_out = sh_q[WIDTH-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else begin
         case (op)
            RD_LOAD:  sh_q <= par_in;
            RD_SHIFT: sh_q <= sh_next;
            default:  sh_q <= sh_q;
         endcase
      end
   end

   // R5 R7
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == RD_LOAD) |=> (sh_q == $past(par_in)));

   // R6
   shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == RD_SHIFT) |=> ($countones(sh_q) <= $countones($past(sh_q))));
endmodule

// File: rtl/sig_compactor.sv
module sig_compactor #(
   parameter int               WIDTH     = sigc_pkg::SIGC_W,
   parameter logic [WIDTH-1:0] POLY      = WIDTH'(sigc_pkg::SIGC_POLY),
   parameter bit               LSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             compact_en,
   input  logic             scan_shift,
   input  logic             scan_bit,
   input  logic             read_sel,
   input  logic             read_load,
   output logic [WIDTH-1:0] sig_out,
   output logic             read_tdo
);
   import sigc_pkg::*;

   logic   adv;
   rd_op_e rd_op;

   assign adv = compact_en & scan_shift & ~read_sel;

   always_comb begin
      if (read_load)                    rd_op = RD_LOAD;
      else if (read_sel && scan_shift)  rd_op = RD_SHIFT;
      else                              rd_op = RD_HOLD;
   end

   sigc_core #(.WIDTH(WIDTH), .POLY(POLY)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (adv),
      .din     (scan_bit),
      .st_q    (sig_out)
   );

   sigc_readout #(.WIDTH(WIDTH), .LSB_FIRST(LSB_FIRST)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (rd_op),
      .par_in  (sig_out),
      .ser_out (read_tdo)
   );

   // R8
   read_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      read_sel |=> $stable(sig_out));

   // R1
   reset_val_chk: assert property (@(posedge clk)
      !rst_n |=> (sig_out == '0 && read_tdo == 1'b0));
endmodule

// File: tb/sim_sig_compactor.sv
`timescale 1ns/1ps
module sim_sig_compactor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        compact_en = 1'b0, scan_shift = 1'b0, scan_bit = 1'b0;
   logic        read_sel = 1'b0, read_load = 1'b0;
   logic [15:0] sig_out;
   logic        read_tdo;
   int          checks = 0, errors = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   sig_compactor u0 (.*);

   // {length[5:0], bits[31:0]}, bits fed LSB first
   localparam logic [37:0] VEC [7] = '{
      {6'd32, 32'h0000_0000},
      {6'd32, 32'hFFFF_FFFF},
      {6'd1,  32'h0000_0001},
      {6'd16, 32'h0000_8001},
      {6'd24, 32'h00A5_5A3C},
      {6'd32, 32'hDEAD_BEEF},
      {6'd20, 32'h000C_0FFE}
   };

   function automatic logic [15:0] model(input logic [15:0] s, input logic b);
      logic f;
      f = s[15] ^ b;
      model = {s[14:0], 1'b0} ^ (f ? 16'h100B : 16'h0000);
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic en, input logic sh, input logic b,
                       input logic rs, input logic rl);
      compact_en = en; scan_shift = sh; scan_bit = b; read_sel = rs; read_load = rl;
      @(negedge clk);
      compact_en = 0; scan_shift = 0; scan_bit = 0; read_sel = 0; read_load = 0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic readout(input string req, input logic [15:0] exp);
      step(0, 0, 0, 0, 1);
      for (int i = 0; i < 16; i++) begin
         chk(req, {15'd0, read_tdo}, {15'd0, exp[i]});
         step(1, 1, ~exp[i], 1, 0);
      end
      chk({req, "/R8"}, sig_out, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] m, first;
      @(negedge clk);
      // R1 during reset
      @(negedge clk);
      chk("R1", sig_out, 16'h0000);
      do_reset();
      chk("R1", sig_out, 16'h0000);
      chk("R1", {15'd0, read_tdo}, 16'h0000);

      // vector table: R2 R4 R6
      foreach (VEC[v]) begin
         do_reset();
         m = 16'h0000;
         for (int i = 0; i < int'(VEC[v][37:32]); i++) begin
            step(1, 1, VEC[v][i], 0, 0);
            m = model(m, VEC[v][i]);
         end
         chk(v == 0 ? "R4" : "R2", sig_out, m);
         readout("R6", m);
      end

      // R3 holds
      do_reset();
      step(1, 1, 1, 0, 0);
      m = model(16'h0000, 1'b1);
      chk("R2", sig_out, m);
      step(1, 0, 1, 0, 0);
      chk("R3 no shift", sig_out, m);
      step(0, 1, 1, 0, 0);
      chk("R3 disabled", sig_out, m);
      step(1, 1, 1, 1, 0);
      chk("R8 read_sel", sig_out, m);
      step(1, 1, 0, 0, 0);
      m = model(m, 1'b0);
      chk("R3 advance", sig_out, m);

      // R5 / R7: load with simultaneous shift
      step(0, 1, 0, 1, 1);
      chk("R7", {15'd0, read_tdo}, {15'd0, m[0]});
      step(0, 1, 0, 1, 0);
      chk("R6", {15'd0, read_tdo}, {15'd0, m[1]});
      step(0, 0, 0, 0, 1);
      chk("R5", {15'd0, read_tdo}, {15'd0, m[0]});

      // R9 reproducibility
      for (int r = 0; r < 2; r++) begin
         do_reset();
         for (int i = 0; i < 32; i++) step(1, 1, VEC[5][i], 0, 0);
         if (r == 0) first = sig_out;
         else chk("R9", sig_out, first);
      end

      // R1 mid-stream reset
      step(1, 1, 1, 0, 0);
      do_reset();
      chk("R1 mid", sig_out, 16'h0000);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule